// File: doc/BRIEF.md
# Separate-Port Burst-of-Two SRAM Request Controller

This controller sits between on-chip logic and an external synchronous SRAM. The SRAM has a dedicated read port, a dedicated write port, and one address bus shared between them, and it moves two data words per access. Users post write requests and read requests into two independent queues through valid/ready handshakes. A write request carries an address, two data words and a byte-enable mask for each word. A read request carries only an address. Each read returns its two words on a response port, together with a small identifier that counts up in issue order.

The block runs on an internal clock at twice the memory cycle rate. A phase flag marks the two halves of each memory cycle:

- In the first half (the K slot), the controller drives the active-low read and write selects, the read address, the first write word and its active-low byte selects.
- In the second half (the K# slot), it drives the write address, the second write word and that word's byte selects.

So one read and one write can go out in every memory cycle. The SRAM returns read data one and a half cycles after the K slot of the request, and the controller captures it at fixed points in time. After reset, both selects stay inactive for a parameterised lock-wait period.

Top module: `qdrm_ctrl`

## Requirements
- R1: While reset is asserted, and in K slots 0 to LOCK_WAIT after reset release, `mem_rps_n` and `mem_wps_n` are both 1. Slot 0 is the K slot in which reset is released. A request that is already queued is issued in K slot LOCK_WAIT+1.
- R2: `k_phase` alternates every internal clock: 0 marks a K slot and 1 marks a K# slot. The selects may be 0 only in a K slot and are 1 in every K# slot.
- R3: In a K slot that issues a read, `mem_addr` carries the read address. In the K# slot that follows an issued write, `mem_addr` carries that write's address.
- R4: An issued write puts data word 0 on `mem_d` in its K slot and data word 1 in the following K# slot. In each of those slots, `mem_bws_n` is the inverse of that word's byte-enable mask. Bit i covers data bits [LANE_W*i +: LANE_W].
- R5: For a read issued in K slot h (counting half-slots), word 0 is taken from `mem_q` during half-slot h+3 and word 1 during half-slot h+4. `rsp_valid` is then high for exactly one internal clock, in half-slot h+5, with both words.
- R6: When both queues hold a request at a K slot after lock, one read and one write are issued in that same slot.
- R7: A K slot with no pending request is a no-op: both selects are high. When no write is in progress, `mem_bws_n` is all ones. A no-op produces no response.
- R8: `rsp_id` starts at 0 after reset and increases by one, modulo 2^IDW, for each read issued.
- R9: A request is accepted when valid and ready are both high. Ready falls when the queue holds QDEPTH entries. Each queue issues its requests in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal clock at twice the memory cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_phase | output | 1 | 0 = K slot, 1 = K# slot |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write queue has room |
| wr_addr | input | AW | Write burst address |
| wr_data0 | input | LANES*LANE_W | First write word |
| wr_data1 | input | LANES*LANE_W | Second write word |
| wr_be0 | input | LANES | Byte enables of the first word (1 = write) |
| wr_be1 | input | LANES | Byte enables of the second word |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read queue has room |
| rd_addr | input | AW | Read burst address |
| rsp_valid | output | 1 | Read response strobe |
| rsp_id | output | IDW | In-order read identifier |
| rsp_data0 | output | LANES*LANE_W | First returned word |
| rsp_data1 | output | LANES*LANE_W | Second returned word |
| mem_rps_n | output | 1 | Read select, active low |
| mem_wps_n | output | 1 | Write select, active low |
| mem_addr | output | AW | Multiplexed address bus |
| mem_d | output | LANES*LANE_W | Write data bus |
| mem_bws_n | output | LANES | Byte write selects, active low |
| mem_q | input | LANES*LANE_W | Read data bus from the SRAM |

## Verification
All timing is counted in half-slots at the falling internal clock edge, which is where the bench samples every output. Bus values for a slot appear one edge after the decision that produces them. The SRAM model queues read words for half-slots h+3 and h+4 and reads the array as those slots arrive, so a same-cycle write is forwarded to the read. The monitor requires each response in exactly half-slot h+5 after its observed read select. The first select is expected in K slot LOCK_WAIT+1, counted from reset release, and each response is compared against a scoreboard entry that holds the data and identifier computed when the request was posted.

// File: rtl/qdrm_pkg.sv
package qdrm_pkg;
  // half-cycle slot within one memory clock cycle
  typedef enum logic {
    SLOT_K  = 1'b0,
    SLOT_KN = 1'b1
  } slot_e;
endpackage

// File: rtl/qdrm_req_fifo.sv
module qdrm_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= din;
  end

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = store_q[rp_q];
endmodule

// File: rtl/qdrm_lock_timer.sv
module qdrm_lock_timer #(
  parameter int LOCK_WAIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic locked
);
  localparam int CW = $clog2(LOCK_WAIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign locked = (cnt_q == CW'(LOCK_WAIT));

  always_comb begin
    cnt_d = cnt_q;
    if (tick && !locked) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qdrm_rd_capture.sv
module qdrm_rd_capture #(
  parameter int DW        = 18,
  parameter int IDW       = 3,
  parameter int LAT_HALF  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [IDW-1:0] issue_id,
  input  logic [DW-1:0]  q_in,
  output logic           rsp_valid,
  output logic [IDW-1:0] rsp_id,
  output logic [DW-1:0]  rsp_d0,
  output logic [DW-1:0]  rsp_d1
);
  // stage k holds a read whose K slot began k edges ago
  localparam int NST = LAT_HALF + 2;

  logic [NST-1:0] vld_q;
  logic [IDW-1:0] idp_q [NST];
  logic [DW-1:0]  w0_q;
  logic           rv_q;
  logic [IDW-1:0] rid_q;
  logic [DW-1:0]  rd0_q, rd1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NST; i++) idp_q[i] <= '0;
    end else begin
      vld_q[0] <= issue;
      idp_q[0] <= issue_id;
      for (int i = 1; i < NST; i++) begin
        vld_q[i] <= vld_q[i-1];
        idp_q[i] <= idp_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q  <= '0;
      rv_q  <= 1'b0;
      rid_q <= '0;
      rd0_q <= '0;
      rd1_q <= '0;
    end else begin
      rv_q <= vld_q[NST-1];
      if (vld_q[NST-2]) w0_q <= q_in;
      if (vld_q[NST-1]) begin
        rid_q <= idp_q[NST-1];
        rd0_q <= w0_q;
        rd1_q <= q_in;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_id    = rid_q;
  assign rsp_d0    = rd0_q;
  assign rsp_d1    = rd1_q;
endmodule

// File: rtl/qdrm_ctrl.sv
module qdrm_ctrl
  import qdrm_pkg::*;
#(
  parameter int AW          = 20,
  parameter int LANES       = 2,
  parameter int LANE_W      = 9,
  parameter int IDW         = 3,
  parameter int QDEPTH      = 4,
  parameter int LOCK_WAIT   = 1024,
  parameter int RD_LAT_HALF = 3
) (
  input  logic                      clk2x,
  input  logic                      rst_n,
  output logic                      k_phase,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [AW-1:0]             wr_addr,
  input  logic [LANES*LANE_W-1:0]   wr_data0,
  input  logic [LANES*LANE_W-1:0]   wr_data1,
  input  logic [LANES-1:0]          wr_be0,
  input  logic [LANES-1:0]          wr_be1,
  input  logic                      rd_valid,
  output logic                      rd_ready,
  input  logic [AW-1:0]             rd_addr,
  output logic                      rsp_valid,
  output logic [IDW-1:0]            rsp_id,
  output logic [LANES*LANE_W-1:0]   rsp_data0,
  output logic [LANES*LANE_W-1:0]   rsp_data1,
  output logic                      mem_rps_n,
  output logic                      mem_wps_n,
  output logic [AW-1:0]             mem_addr,
  output logic [LANES*LANE_W-1:0]   mem_d,
  output logic [LANES-1:0]          mem_bws_n,
  input  logic [LANES*LANE_W-1:0]   mem_q
);
  localparam int DW  = LANES * LANE_W;
  localparam int WQW = AW + 2 * DW + 2 * LANES;

  // write queue
  logic [WQW-1:0] wq_din, wq_dout;
  logic           wq_full, wq_empty, wq_push, wq_pop;
  logic [AW-1:0]  w_addr;
  logic [DW-1:0]  w_d0, w_d1;
  logic [LANES-1:0] w_be0, w_be1;

  // read queue
  logic [AW-1:0]  rq_dout;
  logic           rq_full, rq_empty, rq_push, rq_pop;

  // scheduler
  slot_e          k_ph_q, k_ph_d;
  logic           lock, enter_k, issue_rd, issue_wr;
  logic           rps_q, rps_d, wps_q, wps_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [DW-1:0]  d_q, d_d;
  logic [LANES-1:0] bws_q, bws_d;
  logic           hv_q, hv_d;
  logic [AW-1:0]  ha_q, ha_d;
  logic [DW-1:0]  hd_q, hd_d;
  logic [LANES-1:0] hb_q, hb_d;
  logic [IDW-1:0] id_q, id_d;

  assign wq_din  = {wr_addr, wr_data0, wr_data1, wr_be0, wr_be1};
  assign wq_push = wr_valid && !wq_full;
  assign wr_ready = !wq_full;
  assign w_addr  = wq_dout[WQW-1 -: AW];
  assign w_d0    = wq_dout[2*DW+2*LANES-1 -: DW];
  assign w_d1    = wq_dout[DW+2*LANES-1 -: DW];
  assign w_be0   = wq_dout[2*LANES-1 -: LANES];
  assign w_be1   = wq_dout[LANES-1:0];

  assign rq_push  = rd_valid && !rq_full;
  assign rd_ready = !rq_full;

  qdrm_req_fifo #(.W(WQW), .DEPTH(QDEPTH)) u_wq (
    .clk(clk2x), .rst_n(rst_n), .push(wq_push), .din(wq_din), .full(wq_full),
    .pop(wq_pop), .dout(wq_dout), .empty(wq_empty)
  );

  qdrm_req_fifo #(.W(AW), .DEPTH(QDEPTH)) u_rq (
    .clk(clk2x), .rst_n(rst_n), .push(rq_push), .din(rd_addr), .full(rq_full),
    .pop(rq_pop), .dout(rq_dout), .empty(rq_empty)
  );

  qdrm_lock_timer #(.LOCK_WAIT(LOCK_WAIT)) u_lock (
    .clk(clk2x), .rst_n(rst_n), .tick(enter_k), .locked(lock)
  );

  // the edge that ends a K# slot opens the next K slot
  assign enter_k  = (k_ph_q == SLOT_KN);
  assign issue_rd = enter_k && lock && !rq_empty;
  assign issue_wr = enter_k && lock && !wq_empty;
  assign rq_pop   = issue_rd;
  assign wq_pop   = issue_wr;

  always_comb begin
    k_ph_d = (k_ph_q == SLOT_K) ? SLOT_KN : SLOT_K;
    rps_d  = 1'b1;
    wps_d  = 1'b1;
    addr_d = '0;
    d_d    = '0;
    bws_d  = '1;
    hv_d   = hv_q;
    ha_d   = ha_q;
    hd_d   = hd_q;
    hb_d   = hb_q;
    id_d   = id_q;
    if (enter_k) begin
      rps_d = !issue_rd;
      wps_d = !issue_wr;
      if (issue_rd) begin
        addr_d = rq_dout;
        id_d   = id_q + 1'b1;
      end
      if (issue_wr) begin
        d_d   = w_d0;
        bws_d = ~w_be0;
      end
      hv_d = issue_wr;
      ha_d = w_addr;
      hd_d = w_d1;
      hb_d = w_be1;
    end else if (hv_q) begin
      addr_d = ha_q;
      d_d    = hd_q;
      bws_d  = ~hb_q;
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      k_ph_q <= SLOT_K;
      rps_q  <= 1'b1;
      wps_q  <= 1'b1;
      addr_q <= '0;
      d_q    <= '0;
      bws_q  <= '1;
      id_q   <= '0;
    end else begin
      k_ph_q <= k_ph_d;
      rps_q  <= rps_d;
      wps_q  <= wps_d;
      addr_q <= addr_d;
      d_q    <= d_d;
      bws_q  <= bws_d;
      id_q   <= id_d;
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      ha_q <= '0;
      hd_q <= '0;
      hb_q <= '0;
    end else if (enter_k) begin
      hv_q <= hv_d;
      ha_q <= ha_d;
      hd_q <= hd_d;
      hb_q <= hb_d;
    end
  end

  qdrm_rd_capture #(.DW(DW), .IDW(IDW), .LAT_HALF(RD_LAT_HALF)) u_cap (
    .clk(clk2x), .rst_n(rst_n), .issue(issue_rd), .issue_id(id_q), .q_in(mem_q),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_d0(rsp_data0), .rsp_d1(rsp_data1)
  );

  assign k_phase   = (k_ph_q == SLOT_KN);
  assign mem_rps_n = rps_q;
  assign mem_wps_n = wps_q;
  assign mem_addr  = addr_q;
  assign mem_d     = d_q;
  assign mem_bws_n = bws_q;
endmodule

// File: rtl/qdrm_ctrl_chk.sv
module qdrm_ctrl_chk #(
  parameter int LANES     = 2,
  parameter int LOCK_WAIT = 1024
) (
  input logic             clk2x,
  input logic             rst_n,
  input logic             k_phase,
  input logic             mem_rps_n,
  input logic             mem_wps_n,
  input logic [LANES-1:0] mem_bws_n,
  input logic             rsp_valid
);
  localparam int KW = $clog2(LOCK_WAIT + 2);

  // K slots entered since reset release, saturating
  logic [KW-1:0] kslot_q;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) kslot_q <= '0;
    else if (k_phase && (kslot_q <= KW'(LOCK_WAIT))) kslot_q <= kslot_q + 1'b1;
  end

  // R1
  lock_hold_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (kslot_q <= KW'(LOCK_WAIT)) |-> (mem_rps_n && mem_wps_n));

  // R2
  kn_sel_idle_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    k_phase |-> (mem_rps_n && mem_wps_n));

  // R2
  phase_alt_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    k_phase |=> !k_phase);

  // R2
  phase_alt_back_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !k_phase |=> k_phase);

  // R5
  rsp_pulse_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  rsp_lat_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_rps_n && !k_phase, 5));

  // R7
  idle_bws_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (!k_phase && mem_wps_n) |-> (&mem_bws_n));
endmodule

bind qdrm_ctrl qdrm_ctrl_chk #(.LANES(LANES), .LOCK_WAIT(LOCK_WAIT)) u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .k_phase(k_phase), .mem_rps_n(mem_rps_n),
  .mem_wps_n(mem_wps_n), .mem_bws_n(mem_bws_n), .rsp_valid(rsp_valid)
);

// File: tb/qdrm_ctrl_tb.sv
module qdrm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LANES = 2;
  localparam int LANE_W = 9;
  localparam int DW = LANES * LANE_W;
  localparam int IDW = 3;
  localparam int QDEPTH = 4;
  localparam int LOCK_WAIT = 32;
  localparam int NADDR = 1 << AW;

  logic clk2x = 1'b0;
  logic rst_n;
  logic k_phase;
  logic wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data0, wr_data1;
  logic [LANES-1:0] wr_be0, wr_be1;
  logic rd_valid, rd_ready;
  logic [AW-1:0] rd_addr;
  logic rsp_valid;
  logic [IDW-1:0] rsp_id;
  logic [DW-1:0] rsp_data0, rsp_data1;
  logic mem_rps_n, mem_wps_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_d;
  logic [LANES-1:0] mem_bws_n;
  logic [DW-1:0] mem_q;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  qdrm_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .IDW(IDW), .QDEPTH(QDEPTH),
              .LOCK_WAIT(LOCK_WAIT)) dut_i (
    .clk2x(clk2x), .rst_n(rst_n), .k_phase(k_phase),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_be0(wr_be0), .wr_be1(wr_be1),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
    .mem_rps_n(mem_rps_n), .mem_wps_n(mem_wps_n), .mem_addr(mem_addr),
    .mem_d(mem_d), .mem_bws_n(mem_bws_n), .mem_q(mem_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // SRAM model and reference copy
  logic [DW-1:0] m0 [NADDR];
  logic [DW-1:0] m1 [NADDR];
  logic [DW-1:0] sh0 [NADDR];
  logic [DW-1:0] sh1 [NADDR];

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] en);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[LANE_W*i +: LANE_W] = new_w[LANE_W*i +: LANE_W];
    return r;
  endfunction

  typedef struct packed {
    logic [IDW-1:0] id;
    logic [DW-1:0]  d0;
    logic [DW-1:0]  d1;
  } exp_t;

  exp_t sb_q[$];
  int   iss_q[$];
  int   rd_n = 0;
  int   rsp_n = 0;

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                         input logic [DW-1:0] d1, input logic [LANES-1:0] b0,
                         input logic [LANES-1:0] b1);
    wr_valid = 1'b1; wr_addr = a; wr_data0 = d0; wr_data1 = d1; wr_be0 = b0; wr_be1 = b1;
    while (!wr_ready) @(negedge clk2x);
    sh0[a] = merge(sh0[a], d0, b0);
    sh1[a] = merge(sh1[a], d1, b1);
    @(negedge clk2x);
    wr_valid = 1'b0;
  endtask

  task automatic push_rd(input logic [AW-1:0] a);
    exp_t e;
    rd_valid = 1'b1; rd_addr = a;
    while (!rd_ready) @(negedge clk2x);
    e.id = rd_n[IDW-1:0]; e.d0 = sh0[a]; e.d1 = sh1[a];
    sb_q.push_back(e);
    rd_n++;
    @(negedge clk2x);
    rd_valid = 1'b0;
  endtask

  // monitor: half-slot bookkeeping, SRAM model, protocol and scoreboard
  bit mon_on = 0;
  int sc = 0;
  int kc = 0;
  int first_kc = -1;
  int viol_r1 = 0, viol_r2 = 0, viol_r7 = 0, dual_cnt = 0;
  bit pend_w = 0;
  logic [DW-1:0] pw_d0;
  logic [LANES-1:0] pw_b0;
  bit sch_v [8];
  bit sch_w [8];
  logic [AW-1:0] sch_a [8];

  always @(negedge clk2x) begin
    if (mon_on) begin
      sc++;
      if (!k_phase) begin
        kc++;
        if ((!mem_rps_n || !mem_wps_n) && first_kc < 0) first_kc = kc;
        if ((!mem_rps_n || !mem_wps_n) && kc <= LOCK_WAIT) viol_r1++;
        if (!mem_rps_n && !mem_wps_n) dual_cnt++;
        if (mem_wps_n && mem_bws_n != '1) viol_r7++;
        if (!mem_rps_n) begin
          iss_q.push_back(sc);
          sch_v[(sc+3)&7] = 1; sch_w[(sc+3)&7] = 0; sch_a[(sc+3)&7] = mem_addr;
          sch_v[(sc+4)&7] = 1; sch_w[(sc+4)&7] = 1; sch_a[(sc+4)&7] = mem_addr;
        end
        if (!mem_wps_n) begin
          pend_w = 1; pw_d0 = mem_d; pw_b0 = mem_bws_n;
        end
      end else begin
        if (!mem_rps_n || !mem_wps_n) viol_r2++;
        if (pend_w) begin
          m0[mem_addr] = merge(m0[mem_addr], pw_d0, ~pw_b0);
          m1[mem_addr] = merge(m1[mem_addr], mem_d, ~mem_bws_n);
          pend_w = 0;
        end else if (mem_bws_n != '1) viol_r7++;
      end
      if (sch_v[sc&7]) begin
        mem_q = sch_w[sc&7] ? m1[sch_a[sc&7]] : m0[sch_a[sc&7]];
        sch_v[sc&7] = 0;
      end else mem_q = '0;
      if (rsp_valid) begin
        rsp_n++;
        if (sb_q.size() == 0 || iss_q.size() == 0) begin
          chk(1'b0, "R7", "response without request", rsp_n, 0);
        end else begin
          exp_t e;
          int isc;
          e = sb_q.pop_front();
          isc = iss_q.pop_front();
          chk(sc - isc == 5, "R5", "response half-slot distance", sc - isc, 5);
          chk(rsp_id == e.id, "R8", "response id", rsp_id, e.id);
          chk(rsp_data0 == e.d0 && rsp_data1 == e.d1, "R3/R4", "response data",
              {rsp_data0, rsp_data1}, {e.d0, e.d1});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk2x);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d_before;
    for (int a = 0; a < NADDR; a++) begin
      m0[a] = DW'(a * 37 + 5);  sh0[a] = DW'(a * 37 + 5);
      m1[a] = DW'(a * 91 + 2);  sh1[a] = DW'(a * 91 + 2);
    end
    for (int i = 0; i < 8; i++) sch_v[i] = 0;
    mem_q = '0;
    rst_n = 1'b0;
    wr_valid = 1'b0; rd_valid = 1'b0;
    wr_addr = '0; wr_data0 = '0; wr_data1 = '0; wr_be0 = '0; wr_be1 = '0; rd_addr = '0;
    repeat (4) @(negedge clk2x);
    // R1 / R9: reset state
    chk(mem_rps_n && mem_wps_n, "R1", "selects in reset", {mem_rps_n, mem_wps_n}, 2'b11);
    chk(!rsp_valid, "R5", "rsp_valid in reset", rsp_valid, 0);
    chk(wr_ready && rd_ready, "R9", "ready in reset", {wr_ready, rd_ready}, 2'b11);
    rst_n = 1'b1;
    @(posedge clk2x);
    mon_on = 1;
    @(negedge clk2x);

    // R9: fill the write queue during the lock wait, R4 byte masks
    push_wr(6'd1, 18'h2A5A5, 18'h15A5A, 2'b11, 2'b11);
    push_wr(6'd2, 18'h3FFFF, 18'h00001, 2'b01, 2'b10);
    push_wr(6'd3, 18'h12345, 18'h23456, 2'b10, 2'b01);
    push_wr(6'd4, 18'h00F0F, 18'h0F0F0, 2'b00, 2'b11);
    chk(!wr_ready, "R9", "wr_ready with full queue", wr_ready, 0);
    push_rd(6'd10);
    push_rd(6'd11);

    // wait for lock and drain
    repeat (2 * LOCK_WAIT + 40) @(negedge clk2x);
    chk(first_kc == LOCK_WAIT + 1, "R1", "first issue K slot", first_kc, LOCK_WAIT + 1);
    chk(dual_cnt > 0, "R6", "read and write in same K slot after lock", dual_cnt, 1);
    chk(wr_ready, "R9", "wr_ready after drain", wr_ready, 1);

    // R3/R4/R8: read back written bursts, wrap the id
    for (int a = 1; a <= 4; a++) push_rd(AW'(a));
    for (int a = 30; a < 40; a++) push_rd(AW'(a));
    repeat (30) @(negedge clk2x);

    // R6: simultaneous read and write requests
    d_before = dual_cnt;
    for (int i = 0; i < 6; i++) begin
      fork
        push_wr(AW'(40 + i), DW'(18'h1111 * (i + 1)), DW'(18'h0707 * (i + 3)), 2'b11, 2'b11);
        push_rd(AW'(50 + i));
      join
    end
    repeat (30) @(negedge clk2x);
    chk(dual_cnt - d_before >= 6, "R6", "dual issues for paired requests",
        dual_cnt - d_before, 6);
    for (int i = 0; i < 6; i++) push_rd(AW'(40 + i));

    // R7: idle period, nothing issued and nothing returned
    repeat (60) @(negedge clk2x);
    chk(viol_r1 == 0, "R1", "selects during lock wait", viol_r1, 0);
    chk(viol_r2 == 0, "R2", "selects in K# slots", viol_r2, 0);
    chk(viol_r7 == 0, "R7", "byte selects without write", viol_r7, 0);
    chk(rsp_n == rd_n, "R7", "response count", rsp_n, rd_n);
    chk(sb_q.size() == 0, "R9", "outstanding expected responses", sb_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule